// File: doc/BRIEF.md
# E3 Transmit Overhead Inserter

The block sits in the transmit path of an E3 framer. It receives the outbound frame as a serial bit stream, one bit per clock, with a pulse that marks the first bit of each frame. It rewrites the overhead fields of every frame before the bits leave on `ser_o`, one clock later. The rewritten fields are the alignment word, the alarm (A) and national (N) service bits, a 4-lane interleaved parity nibble and an error-monitor octet. An alarm-indication mode and a loss-of-signal mode override the whole frame.

Software writes three byte-wide registers: configuration, service bits and error mask. A written value reads back at once. It is applied only from the next frame-start pulse, so no frame is ever built from a mix of old and new settings. A pulse from the local receiver reports parity errors in incoming frames. In far-end error mode, those pulses set the A-bit of the following outbound frame.

Frame layout, by bit position counted from 0 at the frame-start pulse:

| Positions | Content |
|---|---|
| 0..9 | alignment word |
| 10 | A-bit |
| 11 | N-bit |
| 12..15 | parity lanes 0..3 |
| 16..23 | error-monitor octet |
| up to `FRAME_BITS`-1 | payload |

Top module: `e3oh_insert`

## Requirements
- R1: While reset is held, `ser_o` and `sof_o` are 0. All register addresses read 0x00.
- R2: Register address 0 (configuration) and address 2 (error mask) store all 8 bits. Address 1 (service bits) stores bit 1 (A value) and bit 0 (N value) and reads 0 in its upper bits. Address 3 ignores writes and reads 0x00. A written value appears on `reg_rdata_o` in the cycle after the write.
- R3: Register writes change the frame output only from the next `sof_i` pulse. Bits of the current frame use the values that were active at its start.
- R4: Configuration bit 0 selects the alignment word. When it is 0, positions 0..9 carry 1111010000, first bit first. When it is 1, they carry `pay_i`.
- R5: When configuration bit 7 is 1, position 12+j carries parity lane j. Lane j is the XOR of every bit at a position congruent to j mod 4 in the previous frame, taken before AIS/LOS forcing. The first frame after reset carries 0000. When bit 7 is 0, these positions carry `pay_i`.
- R6: Configuration bits 6:5 pick the A-bit at position 10: 00 takes service-bit A, 01 takes `oh_i`, 10 takes `pay_i`.
- R7: With A code 11, the A-bit is 1 if `rx_par_err_i` pulsed in any cycle after the previous frame-start cycle, up to and including the current frame-start cycle. Otherwise it is 0.
- R8: Configuration bits 4:3 pick the N-bit at position 11: 00 and 11 take service-bit N, 01 takes `oh_i`, 10 takes `pay_i`.
- R9: Positions 16..23 carry `pay_i` XOR mask bit 7..0, with mask bit 7 applied at position 16. A zero mask leaves the octet unchanged.
- R10: With configuration bit 2 set, every bit at position 10 or beyond is forced to 1.
- R11: With configuration bit 1 set, every output bit is 0. This overrides R10.
- R12: `ser_o` and `sof_o` follow the input bit and `sof_i` with exactly one cycle of latency. Bits outside the overhead positions pass `pay_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bit clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| sof_i | input | 1 | marks bit 0 of a frame |
| pay_i | input | 1 | payload stream bit |
| oh_i | input | 1 | overhead stream bit |
| rx_par_err_i | input | 1 | receiver parity-error pulse |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 2 | register address |
| reg_wdata_i | input | 8 | register write data |
| reg_rdata_o | output | 8 | register read data (staged values) |
| ser_o | output | 1 | outbound bit |
| sof_o | output | 1 | frame start, aligned with `ser_o` |

## Verification
Two events can meet in the frame-start cycle: a new configuration is taken over, and the parity result and the receiver-error flag are handed to the next frame. The bench sweeps all 256 configuration values, one per frame. Each value is written in the middle of the preceding frame, and error pulses are placed on the frame-start cycle itself as well as mid-frame. Every output bit is compared with a bench model. That model switches settings, closes parity and latches the error flag only at the pulse. A bit is judged against the old settings whenever a staged write is still pending, so any early take-over shows up as a miscompare.

// File: rtl/e3oh_pkg.sv
package e3oh_pkg;
  localparam int REG_AW   = 2;
  localparam int REG_DW   = 8;
  localparam int FAW_LEN  = 10;
  localparam logic [FAW_LEN-1:0] FAW_WORD = 10'b1111010000;
  localparam int A_POS    = 10;
  localparam int N_POS    = 11;
  localparam int PAR_POS  = 12;
  localparam int LANES    = 4;
  localparam int EM_POS   = 16;
  localparam int EM_LEN   = 8;
  localparam int OH_END   = EM_POS + EM_LEN;

  localparam logic [REG_AW-1:0] ADDR_CFG  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_SVC  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_MASK = 2'd2;

  typedef enum logic [1:0] {
    SRC_SVC = 2'b00,
    SRC_OH  = 2'b01,
    SRC_PAY = 2'b10,
    SRC_FEB = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic     par_en;
    src_sel_e a_sel;
    src_sel_e n_sel;
    logic     ais;
    logic     los;
    logic     faw_ext;
  } cfg_t;
endpackage

// File: rtl/e3oh_regs.sv
module e3oh_regs
  import e3oh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output cfg_t              cfg_o,
  output logic [1:0]        svc_o,
  output logic [EM_LEN-1:0] mask_o
);
  cfg_t              cfg_s, cfg_a;
  logic [1:0]        svc_s, svc_a;
  logic [EM_LEN-1:0] mask_s, mask_a;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_s  <= '0;
      svc_s  <= '0;
      mask_s <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_CFG:  cfg_s  <= cfg_t'(wdata_i);
        ADDR_SVC:  svc_s  <= wdata_i[1:0];
        ADDR_MASK: mask_s <= wdata_i[EM_LEN-1:0];
        default: ;
      endcase
    end
  end

  // active bank swaps only on frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a  <= '0;
      svc_a  <= '0;
      mask_a <= '0;
    end else if (sof_i) begin
      cfg_a  <= cfg_s;
      svc_a  <= svc_s;
      mask_a <= mask_s;
    end
  end

  // bit 0 of a frame already uses the newly taken-over bank
  assign cfg_o  = sof_i ? cfg_s  : cfg_a;
  assign svc_o  = sof_i ? svc_s  : svc_a;
  assign mask_o = sof_i ? mask_s : mask_a;

  always_comb begin
    unique case (addr_i)
      ADDR_CFG:  rdata_o = REG_DW'(cfg_s);
      ADDR_SVC:  rdata_o = {6'b0, svc_s};
      ADDR_MASK: rdata_o = mask_s;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/e3oh_timing.sv
module e3oh_timing #(
  parameter int FRAME_BITS = 1536,
  localparam int CW = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  input  logic          err_i,
  output logic [CW-1:0] pos_o,
  output logic          seen_o,
  output logic          feb_o
);
  logic [CW-1:0] cnt_q;
  logic          err_acc_q;

  assign pos_o = sof_i ? '0 :
                 (cnt_q == CW'(FRAME_BITS-1)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      seen_o    <= 1'b0;
      err_acc_q <= 1'b0;
      feb_o     <= 1'b0;
    end else begin
      cnt_q <= pos_o;
      if (sof_i) begin
        seen_o    <= 1'b1;
        feb_o     <= err_acc_q | err_i;
        err_acc_q <= 1'b0;
      end else begin
        err_acc_q <= err_acc_q | err_i;
      end
    end
  end
endmodule

// File: rtl/e3oh_parity.sv
module e3oh_parity
  import e3oh_pkg::*;
#(
  localparam int LW = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             seen_i,
  input  logic [LW-1:0]    lane_i,
  input  logic             bit_i,
  output logic [LANES-1:0] par_o
);
  logic [LANES-1:0] acc_q, acc_n;

  always_comb begin
    acc_n         = sof_i ? '0 : acc_q;
    acc_n[lane_i] = acc_n[lane_i] ^ bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      par_o <= '0;
    end else begin
      acc_q <= acc_n;
      // bits seen before the first frame start are discarded
      if (sof_i) par_o <= seen_i ? acc_q : '0;
    end
  end
endmodule

// File: rtl/e3oh_insert.sv
// FRAME_BITS must be at least 24 so the overhead fits.
module e3oh_insert
  import e3oh_pkg::*;
#(
  parameter int FRAME_BITS = 1536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              pay_i,
  input  logic              oh_i,
  input  logic              rx_par_err_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              ser_o,
  output logic              sof_o
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam int LW = $clog2(LANES);

  cfg_t              act_cfg;
  logic [1:0]        act_svc;
  logic [EM_LEN-1:0] act_mask;
  logic [CW-1:0]     pos_c;
  logic              seen_q, feb_q;
  logic [LANES-1:0]  par_q;
  logic              raw_bit, out_bit, in_faw;

  e3oh_regs u_regs (
    .clk_i, .rst_ni, .sof_i,
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (act_cfg),
    .svc_o   (act_svc),
    .mask_o  (act_mask)
  );

  e3oh_timing #(.FRAME_BITS(FRAME_BITS)) u_timing (
    .clk_i, .rst_ni, .sof_i,
    .err_i  (rx_par_err_i),
    .pos_o  (pos_c),
    .seen_o (seen_q),
    .feb_o  (feb_q)
  );

  e3oh_parity u_parity (
    .clk_i, .rst_ni, .sof_i,
    .seen_i (seen_q),
    .lane_i (pos_c[LW-1:0]),
    .bit_i  (raw_bit),
    .par_o  (par_q)
  );

  function automatic logic pick(src_sel_e s, logic svc, logic oh, logic pay, logic feb);
    unique case (s)
      SRC_SVC: return svc;
      SRC_OH:  return oh;
      SRC_PAY: return pay;
      default: return feb;
    endcase
  endfunction

  always_comb begin
    int p;
    logic [3:0]    faw_idx;
    logic [LW-1:0] par_idx;
    logic [2:0]    em_idx;
    p       = int'(pos_c);
    faw_idx = 4'(FAW_LEN - 1 - p);
    par_idx = LW'(p - PAR_POS);
    em_idx  = 3'(EM_LEN - 1 - (p - EM_POS));
    in_faw  = p < FAW_LEN;
    if (in_faw)
      raw_bit = act_cfg.faw_ext ? pay_i : FAW_WORD[faw_idx];
    else if (p == A_POS)
      raw_bit = pick(act_cfg.a_sel, act_svc[1], oh_i, pay_i, feb_q);
    else if (p == N_POS)
      raw_bit = pick((act_cfg.n_sel == SRC_FEB) ? SRC_SVC : act_cfg.n_sel,
                     act_svc[0], oh_i, pay_i, 1'b0);
    else if (p < PAR_POS + LANES)
      raw_bit = act_cfg.par_en ? par_q[par_idx] : pay_i;
    else if (p < OH_END)
      raw_bit = pay_i ^ act_mask[em_idx];
    else
      raw_bit = pay_i;

    if (act_cfg.los)                out_bit = 1'b0;
    else if (act_cfg.ais && !in_faw) out_bit = 1'b1;
    else                             out_bit = raw_bit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_o <= 1'b0;
      sof_o <= 1'b0;
    end else begin
      ser_o <= out_bit;
      sof_o <= sof_i;
    end
  end
endmodule

// File: rtl/e3oh_chk.sv
module e3oh_chk
  import e3oh_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sof_i,
  input logic             sof_o,
  input logic             ser_o,
  input cfg_t             act_cfg,
  input logic             in_faw,
  input logic             seen_q,
  input logic [LANES-1:0] par_q
);
  a_r12_sof_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> sof_o);

  a_r11_los_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_cfg.los |=> !ser_o);

  a_r10_ais_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_cfg.ais && !act_cfg.los && !in_faw) |=> ser_o);

  a_r4_faw_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !act_cfg.faw_ext && !act_cfg.los) |=> ser_o);

  a_r5_first_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (par_q == '0));

  a_r3_hold_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> (sof_i || $stable(act_cfg)));
endmodule

bind e3oh_insert e3oh_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sof_i   (sof_i),
  .sof_o   (sof_o),
  .ser_o   (ser_o),
  .act_cfg (act_cfg),
  .in_faw  (in_faw),
  .seen_q  (seen_q),
  .par_q   (par_q)
);

// File: tb/sim_e3oh_insert.sv
`timescale 1ns/1ps
module sim_e3oh_insert;
  localparam int FB = 32;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       sof_i = 0, pay_i = 0, oh_i = 0, rx_par_err_i = 0, reg_we_i = 0;
  logic [1:0] reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic       ser_o, sof_o;

  always #5ns clk_i = ~clk_i;

  e3oh_insert #(.FRAME_BITS(FB)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic [7:0] st_cfg = 0, st_mask = 0, ac_cfg = 0, ac_mask = 0;
  logic [1:0] st_svc = 0, ac_svc = 0;
  logic [3:0] m_acc = 0, m_par = 0;
  bit m_seen = 0, m_eacc = 0, m_feb = 0;
  bit have_prev = 0, prev_exp = 0, prev_sof = 0;
  string prev_tag;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_bit(input int pos, input bit sof, input bit pay, input bit oh,
                           input bit err, input bit we, input logic [1:0] addr,
                           input logic [7:0] wd);
    bit raw, exp, pend;
    string t;
    @(negedge clk_i);
    if (have_prev) begin
      check(prev_tag, {7'b0, ser_o}, {7'b0, prev_exp});
      check("R12 sof_o", {7'b0, sof_o}, {7'b0, prev_sof});
    end
    sof_i = sof; pay_i = pay; oh_i = oh; rx_par_err_i = err;
    reg_we_i = we; reg_addr_i = addr; reg_wdata_i = wd;
    if (sof) begin
      ac_cfg = st_cfg; ac_svc = st_svc; ac_mask = st_mask;
      m_feb = m_eacc | err; m_eacc = 0;
      m_par = m_seen ? m_acc : 4'b0; m_seen = 1; m_acc = 0;
    end else m_eacc = m_eacc | err;
    pend = (st_cfg != ac_cfg);
    if (pos < 10) begin
      raw = ac_cfg[0] ? pay : ((10'b1111010000 >> (9 - pos)) & 1) != 0; t = "R4";
    end else if (pos == 10) begin
      case (ac_cfg[6:5])
        2'b00: raw = ac_svc[1];
        2'b01: raw = oh;
        2'b10: raw = pay;
        default: raw = m_feb;
      endcase
      t = (ac_cfg[6:5] == 2'b11) ? "R7" : "R6";
    end else if (pos == 11) begin
      case (ac_cfg[4:3])
        2'b01: raw = oh;
        2'b10: raw = pay;
        default: raw = ac_svc[0];
      endcase
      t = "R8";
    end else if (pos < 16) begin
      raw = ac_cfg[7] ? m_par[pos-12] : pay; t = "R5";
    end else if (pos < 24) begin
      raw = pay ^ ac_mask[23 - pos]; t = "R9";
    end else begin
      raw = pay; t = "R12";
    end
    if (ac_cfg[1]) begin exp = 0; t = "R11"; end
    else if (ac_cfg[2] && pos >= 10) begin exp = 1; t = "R10"; end
    else exp = raw;
    m_acc[pos % 4] = m_acc[pos % 4] ^ raw;
    if (we) begin
      case (addr)
        2'd0: st_cfg = wd;
        2'd1: st_svc = wd[1:0];
        2'd2: st_mask = wd;
        default: ;
      endcase
    end
    prev_exp = exp; prev_sof = sof; have_prev = 1;
    prev_tag = pend ? {"R3 ", t} : t;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
    case (a)
      2'd0: st_cfg = d;
      2'd1: st_svc = d[1:0];
      2'd2: st_mask = d;
      default: ;
    endcase
  endtask

  task automatic reg_read(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr_i = a;
    #1ns;
    check(req, reg_rdata_o, exp);
  endtask

  initial begin
    // R1: reset state
    #12ns;
    for (int a = 0; a < 4; a++) reg_read("R1 rdata", 2'(a), 8'h00);
    check("R1 ser_o", {7'b0, ser_o}, 8'h00);
    check("R1 sof_o", {7'b0, sof_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1;

    // R2: register storage and readback
    reg_write(2'd0, 8'hA5); reg_read("R2 cfg", 2'd0, 8'hA5);
    reg_write(2'd1, 8'hFF); reg_read("R2 svc", 2'd1, 8'h03);
    reg_write(2'd2, 8'h3C); reg_read("R2 mask", 2'd2, 8'h3C);
    reg_write(2'd3, 8'h77); reg_read("R2 addr3", 2'd3, 8'h00);
    reg_read("R2 cfg kept", 2'd0, 8'hA5);

    // sweep every configuration value, one per frame, staged mid-frame
    for (int f = 0; f <= 256; f++) begin
      for (int p = 0; p < FB; p++) begin
        bit pay, oh, err, we;
        logic [1:0] ad;
        logic [7:0] wd;
        pay = (((f * 5 + p * 3 + ((p * p) >> 2)) >> 1) & 1) != 0;
        oh  = ((((f + p * 7) >> 2) ^ p) & 1) != 0;
        err = (p == 20 && f % 3 == 0) || (p == 0 && f % 5 == 0);
        we = 0; ad = 2'd0; wd = 8'h00;
        if (p == 5)      begin we = 1; ad = 2'd0; wd = 8'(f); end
        else if (p == 6) begin we = 1; ad = 2'd1; wd = 8'(f ^ (f >> 2)); end
        else if (p == 7) begin we = 1; ad = 2'd2; wd = 8'(f * 37); end
        drive_bit(p, p == 0, pay, oh, err, we, ad, wd);
        if (p == 8) reg_read("R2 staged cfg", 2'd0, st_cfg);
      end
    end
    @(negedge clk_i);
    check(prev_tag, {7'b0, ser_o}, {7'b0, prev_exp});
    check("R12 sof_o", {7'b0, sof_o}, {7'b0, prev_sof});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule